// File: doc/BRIEF.md
# Dual Phase-Frequency Comparator with Lock Detection

This block holds two independent phase-frequency comparator sections and runs on the reference-oscillator clock. Each section watches two single-cycle strobes: one marks an edge of the divided reference, the other an edge of the divided feedback. The section produces a three-state charge-pump command. The command is high-impedance when the two edges line up. Otherwise it holds a drive level for as many clock cycles as one strobe leads the other. A per-section polarity input swaps the two drive levels to suit the oscillator slope and the loop filter.

Each section also measures the width of every phase-error pulse in clock cycles. A wide error clears that section's lock at once. Lock returns only after a run of narrow errors. The lock results of the two sections are ANDed, and a section held in power-save counts as locked. One shared output pin carries either this combined lock or, in monitor mode, one raw strobe picked by a two-bit selector.

A section held in power-save drives high-impedance and forgets its comparison state. On the first comparison after it is released, the pump command is clamped to one clock so that the controlled oscillator does not jump.

Top module: `dual_pfd_lock`

## Requirements
- R1: Pump command encoding per section is 2'b00 high-impedance, 2'b01 drive high, 2'b10 drive low. With polarity 1, a reference strobe that arrives before the feedback strobe gives drive high in the cycles from the clock after the reference strobe up to and including the clock of the feedback strobe. After that the command returns to 2'b00. A feedback strobe that leads gives drive low.
- R2: With polarity 0 the two drive levels are swapped: a leading reference gives drive low and a leading feedback gives drive high.
- R3: Reference and feedback strobes in the same cycle give a zero-width error and leave the command at high-impedance. A second strobe from the side that already leads does not end the pulse. Only the lagging side's strobe ends it, so the error saturates instead of wrapping.
- R4: A comparison whose error width is 2 clock cycles or more clears that section's lock in the cycle after the comparison ends.
- R5: A section becomes locked after three consecutive comparisons with an error width below 2 cycles, and not after only two.
- R6: With the monitor mode input low, the shared output is high only when every section is either locked or has its power-save input low.
- R7: While a section's power-save input is low, its command is high-impedance in that same cycle. Its pending comparison and its lock are discarded.
- R8: With the monitor mode input high, the shared output shows one raw strobe. Selector bit 0 picks the section and selector bit 1 picks feedback (1) or reference (0): 00 is section 0 reference, 01 is section 1 reference, 10 is section 0 feedback, 11 is section 1 feedback.
- R9: On the first comparison after a power-save release, the drive lasts at most one clock cycle and the rest of the error is high-impedance. Later comparisons drive for their full width.
- R10: After reset every command is high-impedance and no section is locked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 2 | Per-section divided reference strobe, one cycle per edge |
| fb_tick | input | 2 | Per-section divided feedback strobe, one cycle per edge |
| ps_n | input | 2 | Per-section run enable; low puts the section in power-save |
| pol | input | 2 | Per-section polarity; 1 means a leading reference drives high |
| mon_en | input | 1 | Shared pin shows a monitor strobe when high, combined lock when low |
| mon_pick | input | 2 | Monitor selector: bit 0 section, bit 1 feedback or reference |
| cp_drive | output | 4 | Pump commands, section n in bits [2n+1:2n] |
| share_out | output | 1 | Shared lock / monitor pin |

## Verification
The hardest conditions to reach from the ports are the clamped first comparison and the lock hysteresis. Both depend on history: how many narrow errors came in a row, and whether a power-save release came before the current comparison. The stimulus builds these histories on purpose. It first breaks lock with a wide error, then walks narrow errors one at a time while it watches the shared pin. It toggles power-save in the middle of a live pulse before it opens a wide comparison that must be clamped to one cycle.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;

    localparam int CNT_W = 8;

    typedef enum logic [1:0] {
        DRV_Z  = 2'b00,
        DRV_HI = 2'b01,
        DRV_LO = 2'b10
    } drv_t;

    typedef enum logic [1:0] {
        PH_IDLE     = 2'b00,
        PH_REF_LEAD = 2'b01,
        PH_FB_LEAD  = 2'b10
    } phase_t;

    typedef struct packed {
        logic             done;
        logic [CNT_W-1:0] width;
    } cmp_result_t;

    function automatic drv_t lead_to_drive(input logic ref_ahead, input logic polarity);
        return (ref_ahead == polarity) ? DRV_HI : DRV_LO;
    endfunction

endpackage

// File: rtl/pfd_phase_core.sv
module pfd_phase_core
    import pfd_lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ref_tick,
    input  logic        fb_tick,
    input  logic        enable,
    input  logic        polarity,
    output drv_t        drive,
    output cmp_result_t result
);
    phase_t           st;
    logic [CNT_W-1:0] wcnt;
    logic             first_cmp;
    logic             pulse_ok;

    // a comparison closes when the lagging strobe arrives, or both coincide
    always_comb begin
        result.done = enable && (
            (st == PH_IDLE     && ref_tick && fb_tick)  ||
            (st == PH_REF_LEAD && fb_tick  && !ref_tick) ||
            (st == PH_FB_LEAD  && ref_tick && !fb_tick));
        result.width = (st == PH_IDLE) ? '0 : wcnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= PH_IDLE;
            wcnt      <= '0;
            first_cmp <= 1'b0;
        end else if (!enable) begin
            st        <= PH_IDLE;
            wcnt      <= '0;
            first_cmp <= 1'b1;
        end else begin
            if (result.done) first_cmp <= 1'b0;
            unique case (st)
                PH_IDLE: begin
                    if (ref_tick ^ fb_tick) begin
                        st   <= ref_tick ? PH_REF_LEAD : PH_FB_LEAD;
                        wcnt <= CNT_W'(1);
                    end
                end
                PH_REF_LEAD: begin
                    if (fb_tick && !ref_tick) begin
                        st   <= PH_IDLE;
                        wcnt <= '0;
                    end else if (wcnt != '1) begin
                        wcnt <= wcnt + CNT_W'(1);
                    end
                end
                PH_FB_LEAD: begin
                    if (ref_tick && !fb_tick) begin
                        st   <= PH_IDLE;
                        wcnt <= '0;
                    end else if (wcnt != '1) begin
                        wcnt <= wcnt + CNT_W'(1);
                    end
                end
                default: begin
                    st   <= PH_IDLE;
                    wcnt <= '0;
                end
            endcase
        end
    end

    assign pulse_ok = !first_cmp || (wcnt == CNT_W'(1));

    always_comb begin
        if (!enable || st == PH_IDLE || !pulse_ok)
            drive = DRV_Z;
        else
            drive = lead_to_drive(st == PH_REF_LEAD, polarity);
    end

endmodule

// File: rtl/pfd_lock_tracker.sv
module pfd_lock_tracker
    import pfd_lock_pkg::*;
#(
    parameter int UNLOCK_W  = 2,
    parameter int LOCK_W    = 4,
    parameter int GOOD_RUNS = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  cmp_result_t result,
    output logic        locked
);
    localparam int               RUN_W    = $clog2(GOOD_RUNS + 1);
    localparam logic [CNT_W-1:0] UNL_LIM  = CNT_W'(UNLOCK_W);
    localparam logic [CNT_W-1:0] LCK_LIM  = CNT_W'(LOCK_W);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(GOOD_RUNS - 1);

    logic [RUN_W-1:0] run;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            run    <= '0;
            locked <= 1'b0;
        end else if (result.done) begin
            if (result.width >= UNL_LIM) begin
                run    <= '0;
                locked <= 1'b0;
            end else if (result.width <= LCK_LIM) begin
                if (run >= RUN_LAST) locked <= 1'b1;
                else                 run    <= run + RUN_W'(1);
            end else begin
                run    <= '0;
                locked <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pfd_monitor_mux.sv
module pfd_monitor_mux #(
    parameter int NSEC = 2,
    parameter int SEL_W = $clog2(NSEC) + 1
) (
    input  logic             lock_all,
    input  logic             mon_en,
    input  logic [SEL_W-1:0] pick,
    input  logic [NSEC-1:0]  ref_tick,
    input  logic [NSEC-1:0]  fb_tick,
    output logic             pin
);
    logic [SEL_W-2:0] sec;
    logic             strobe;

    assign sec    = pick[SEL_W-2:0];
    assign strobe = pick[SEL_W-1] ? fb_tick[sec] : ref_tick[sec];
    assign pin    = mon_en ? strobe : lock_all;

endmodule

// File: rtl/dual_pfd_lock.sv
module dual_pfd_lock
    import pfd_lock_pkg::*;
#(
    parameter int NSEC      = 2,
    parameter int UNLOCK_W  = 2,
    parameter int LOCK_W    = 4,
    parameter int GOOD_RUNS = 3,
    localparam int SEL_W    = $clog2(NSEC) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSEC-1:0]   ref_tick,
    input  logic [NSEC-1:0]   fb_tick,
    input  logic [NSEC-1:0]   ps_n,
    input  logic [NSEC-1:0]   pol,
    input  logic              mon_en,
    input  logic [SEL_W-1:0]  mon_pick,
    output logic [2*NSEC-1:0] cp_drive,
    output logic              share_out
);
    logic [NSEC-1:0]       done_v;
    logic [NSEC-1:0]       locked_v;
    logic [NSEC*CNT_W-1:0] width_flat;
    logic                  lock_all;

    for (genvar i = 0; i < NSEC; i++) begin : g_sec
        drv_t        drv;
        cmp_result_t res;

        pfd_phase_core u_core (
            .clk      (clk),
            .rst      (rst),
            .ref_tick (ref_tick[i]),
            .fb_tick  (fb_tick[i]),
            .enable   (ps_n[i]),
            .polarity (pol[i]),
            .drive    (drv),
            .result   (res)
        );

        pfd_lock_tracker #(
            .UNLOCK_W  (UNLOCK_W),
            .LOCK_W    (LOCK_W),
            .GOOD_RUNS (GOOD_RUNS)
        ) u_lock (
            .clk    (clk),
            .rst    (rst),
            .enable (ps_n[i]),
            .result (res),
            .locked (locked_v[i])
        );

        assign cp_drive[2*i +: 2]            = drv;
        assign done_v[i]                     = res.done;
        assign width_flat[i*CNT_W +: CNT_W]  = res.width;
    end

    assign lock_all = &(locked_v | ~ps_n);

    pfd_monitor_mux #(
        .NSEC  (NSEC),
        .SEL_W (SEL_W)
    ) u_mux (
        .lock_all (lock_all),
        .mon_en   (mon_en),
        .pick     (mon_pick),
        .ref_tick (ref_tick),
        .fb_tick  (fb_tick),
        .pin      (share_out)
    );

endmodule

// File: rtl/dual_pfd_lock_chk.sv
module dual_pfd_lock_chk #(
    parameter int NSEC     = 2,
    parameter int CW       = 8,
    parameter int UNLOCK_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [NSEC-1:0]   ps_n,
    input logic              mon_en,
    input logic [2*NSEC-1:0] cp_drive,
    input logic              share_out,
    input logic [NSEC-1:0]   done_v,
    input logic [NSEC-1:0]   locked_v,
    input logic [NSEC*CW-1:0] width_flat
);
    for (genvar i = 0; i < NSEC; i++) begin : g_chk
        // R1
        drv_legal_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0(cp_drive[2*i +: 2]));

        // R7
        save_hiz_chk: assert property (@(posedge clk) disable iff (rst)
            !ps_n[i] |-> cp_drive[2*i +: 2] == 2'b00);

        // R5
        lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(locked_v[i]) |-> $past(done_v[i]));

        // R4
        wide_unlock_chk: assert property (@(posedge clk) disable iff (rst)
            (done_v[i] && width_flat[i*CW +: CW] >= CW'(UNLOCK_W)) |=> !locked_v[i]);
    end

    // R6
    all_save_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (!mon_en && ps_n == '0) |-> share_out);

endmodule

bind dual_pfd_lock dual_pfd_lock_chk #(
    .NSEC     (NSEC),
    .CW       (pfd_lock_pkg::CNT_W),
    .UNLOCK_W (UNLOCK_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ps_n       (ps_n),
    .mon_en     (mon_en),
    .cp_drive   (cp_drive),
    .share_out  (share_out),
    .done_v     (done_v),
    .locked_v   (locked_v),
    .width_flat (width_flat)
);

// File: tb/dual_pfd_lock_test.sv
module dual_pfd_lock_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ref_r = 2'b00;
    logic [1:0] fb_r = 2'b00;
    logic [1:0] ps_r = 2'b11;
    logic [1:0] pol_r = 2'b11;
    logic       mon_r = 1'b0;
    logic [1:0] pick_r = 2'b00;
    logic [3:0] cp_drive;
    logic       share_out;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dual_pfd_lock uut (
        .clk       (clk),
        .rst       (rst),
        .ref_tick  (ref_r),
        .fb_tick   (fb_r),
        .ps_n      (ps_r),
        .pol       (pol_r),
        .mon_en    (mon_r),
        .mon_pick  (pick_r),
        .cp_drive  (cp_drive),
        .share_out (share_out)
    );

    // vector: {ref leads, width, polarity}
    localparam logic [5:0] VEC [8] = '{
        {1'b1, 4'd1, 1'b1}, {1'b1, 4'd3, 1'b1}, {1'b0, 4'd2, 1'b1}, {1'b0, 4'd4, 1'b1},
        {1'b1, 4'd5, 1'b0}, {1'b0, 4'd3, 1'b0}, {1'b1, 4'd0, 1'b1}, {1'b0, 4'd6, 1'b0}
    };

    task automatic check(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic run_cmp(input bit lead, input int d, input bit p, input int live, input string req);
        int exp_lv;
        exp_lv = (lead == p) ? 1 : 2;
        @(negedge clk);
        pol_r[0] = p;
        if (d == 0) begin
            ref_r[0] = 1'b1; fb_r[0] = 1'b1;
            @(negedge clk);
            ref_r[0] = 1'b0; fb_r[0] = 1'b0;
            check(req, int'(cp_drive[1:0]), 0);
        end else begin
            if (lead) ref_r[0] = 1'b1; else fb_r[0] = 1'b1;
            for (int k = 1; k <= d; k++) begin
                @(negedge clk);
                ref_r[0] = 1'b0; fb_r[0] = 1'b0;
                check(req, int'(cp_drive[1:0]), (k <= live) ? exp_lv : 0);
                if (k == d) begin
                    if (lead) fb_r[0] = 1'b1; else ref_r[0] = 1'b1;
                end
            end
            @(negedge clk);
            ref_r[0] = 1'b0; fb_r[0] = 1'b0;
            check(req, int'(cp_drive[1:0]), 0);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: got 0 expected 1 (run ended)");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 drive in reset", int'(cp_drive), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R10 drive after reset", int'(cp_drive), 0);
        check("R10 no lock after reset", int'(share_out), 0);

        // R1 R2 R3: vector walk on section 0, section 1 saved
        ps_r = 2'b01;
        foreach (VEC[i]) begin
            run_cmp(VEC[i][5], int'(VEC[i][4:1]), VEC[i][0], int'(VEC[i][4:1]),
                    VEC[i][0] ? "R1 table" : "R2 table");
        end

        // R3: repeated lead strobe does not close the pulse
        @(negedge clk);
        pol_r[0] = 1'b1; ref_r[0] = 1'b1;
        @(negedge clk); ref_r[0] = 1'b0;
        check("R3 saturate c1", int'(cp_drive[1:0]), 1);
        @(negedge clk); ref_r[0] = 1'b1;
        check("R3 saturate c2", int'(cp_drive[1:0]), 1);
        @(negedge clk); ref_r[0] = 1'b0; fb_r[0] = 1'b1;
        check("R3 saturate c3", int'(cp_drive[1:0]), 1);
        @(negedge clk); fb_r[0] = 1'b0;
        check("R3 closed by lagging strobe", int'(cp_drive[1:0]), 0);
        repeat (2) @(negedge clk);

        // R4 R5: lock hysteresis through the shared pin
        run_cmp(1'b1, 5, 1'b1, 5, "R4 wide");
        check("R4 wide error unlocked", int'(share_out), 0);
        run_cmp(1'b1, 1, 1'b1, 1, "R5 narrow1");
        run_cmp(1'b0, 1, 1'b1, 1, "R5 narrow2");
        check("R5 two narrow not locked", int'(share_out), 0);
        run_cmp(1'b1, 1, 1'b0, 1, "R5 narrow3");
        check("R5 three narrow locked", int'(share_out), 1);
        run_cmp(1'b0, 2, 1'b1, 2, "R4 width2");
        check("R4 width 2 unlocks", int'(share_out), 0);
        run_cmp(1'b1, 0, 1'b1, 0, "R5 zero1");
        run_cmp(1'b1, 0, 1'b1, 0, "R5 zero2");
        run_cmp(1'b1, 0, 1'b1, 0, "R5 zero3");
        check("R5 three zero-width locked", int'(share_out), 1);

        // R6: combine with power-save
        ps_r = 2'b11; @(negedge clk);
        check("R6 section1 running unlocked", int'(share_out), 0);
        ps_r = 2'b00; @(negedge clk);
        check("R6 both saved", int'(share_out), 1);
        ps_r = 2'b01; @(negedge clk);
        check("R6 section0 lock discarded", int'(share_out), 0);

        // R7: save in the middle of a live pulse
        pol_r[0] = 1'b1; ref_r[0] = 1'b1;
        @(negedge clk); ref_r[0] = 1'b0;
        check("R7 pulse live", int'(cp_drive[1:0]), 1);
        ps_r[0] = 1'b0; #1;
        check("R7 immediate hiz", int'(cp_drive[1:0]), 0);
        @(negedge clk); ps_r[0] = 1'b1;
        @(negedge clk);
        check("R7 pending discarded", int'(cp_drive[1:0]), 0);
        repeat (2) @(negedge clk);

        // R9: first comparison after release is clamped
        run_cmp(1'b1, 3, 1'b1, 1, "R9 clamped");
        run_cmp(1'b1, 3, 1'b1, 3, "R9 full after");

        // R8: monitor selection
        mon_r = 1'b1;
        ps_r = 2'b00;
        @(negedge clk);
        ref_r = 2'b10; fb_r = 2'b00; pick_r = 2'b01; #1;
        check("R8 pick01 section1 ref", int'(share_out), 1);
        pick_r = 2'b00; #1;
        check("R8 pick00 section0 ref", int'(share_out), 0);
        ref_r = 2'b00; fb_r = 2'b01; pick_r = 2'b10; #1;
        check("R8 pick10 section0 fb", int'(share_out), 1);
        pick_r = 2'b11; #1;
        check("R8 pick11 section1 fb", int'(share_out), 0);
        @(negedge clk);
        fb_r = 2'b00;
        @(negedge clk);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule